// File: doc/BRIEF.md
# Converter Fault Protection Supervisor

This block decides whether a switching power converter may drive its power switch. It receives already-digitized comparator events (supply level flags, feedback-pin over- and under-voltage, an overload compare on the compensation node, over-temperature flags and a deep-supply-collapse flag) and per-cycle strobes from the gate timer. From these it produces a run enable for the gate timer, a soft-start flag, and a latched-fault status.

A synchronous state machine with five states carries the behaviour. `ST_LOCKOUT` waits for the supply to pass the turn-on level. `ST_SOFTSTART` runs the converter for a fixed number of milliseconds with the soft-start flag set and then moves to `ST_RUN`. `ST_THERMAL` holds switching off while the die is hot and returns through soft-start when it has cooled past the hysteresis point. `ST_LATCHED` keeps switching off after a hard fault until the supply collapses below the release level, then goes back to `ST_LOCKOUT`. Named transitions: power-up (LOCKOUT→SOFTSTART on turn-on flag, die not hot), ramp-done (SOFTSTART→RUN when the soft-start timer ends), brown-out (SOFTSTART/RUN/THERMAL→LOCKOUT on turn-off flag), trip (SOFTSTART/RUN/THERMAL→LATCHED on supply over-voltage; SOFTSTART/RUN→LATCHED on feedback under-voltage in gate-off, debounced feedback over-voltage or expired overload delay), overheat (SOFTSTART/RUN→THERMAL), cooled (THERMAL→SOFTSTART) and release (LATCHED→LOCKOUT). Within switching states the order of precedence is turn-off flag, supply over-voltage, feedback under-voltage, feedback over-voltage, overload, over-temperature.

Millisecond windows come from a free-running prescaler that divides the system clock into a one-millisecond tick, so each millisecond window may run short by up to one tick period.

Top module: `flyback_guard`

## Requirements
- R1: Switching (run_en high) starts only when sup_above_on is high in ST_LOCKOUT; once switching, it stops and the machine returns to lockout in the cycle after sup_below_off rises; with both supply flags low the current switching or non-switching state is kept.
- R2: When sup_ovp is high in a switching state, run_en is low in that same cycle, and fault_latched is high from the next cycle.
- R3: fault_latched rises after FBOVP_CYCLES (default 8) consecutive cyc_end strobes that each see fb_ovp high; a cyc_end strobe with fb_ovp low restarts the count.
- R4: fb_uvp while gate_off is high in a switching state latches the fault in the next cycle; fb_uvp while gate_off is low has no effect.
- R5: After power-up, ss_active and run_en are both high for SS_MS milliseconds (between (SS_MS-1)*TICK_DIV+1 and SS_MS*TICK_DIV+2 clock cycles), after which ss_active falls and run_en stays high.
- R6: ovl_cmp held high in ST_RUN for OLP_MS milliseconds latches the fault; any deassertion restarts the delay; ovl_cmp during soft-start does not count.
- R7: While latched, run_en stays low and fault_latched stays high whatever sup_above_on, sup_below_off or sup_ovp do, until rel_low is high.
- R8: rel_low in ST_LATCHED clears fault_latched in the next cycle and enters lockout; switching then needs sup_above_on again.
- R9: temp_hot in a switching state stops switching without latching; switching resumes through soft-start only once temp_cool is high; temp_hot in lockout blocks power-up.
- R10: During and right after reset run_en, ss_active and fault_latched are low (ST_LOCKOUT).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_above_on | input | 1 | Supply above the turn-on level |
| sup_below_off | input | 1 | Supply below the turn-off level |
| sup_ovp | input | 1 | Supply above the over-voltage level |
| fb_ovp | input | 1 | Feedback pin above its over-voltage level |
| fb_uvp | input | 1 | Feedback pin below its under-voltage level |
| gate_off | input | 1 | Gate is in its off interval (feedback sampling window) |
| cyc_end | input | 1 | One-cycle strobe at the end of each switching cycle |
| ovl_cmp | input | 1 | Compensation node at or above the overload level |
| temp_hot | input | 1 | Die above the over-temperature trip point |
| temp_cool | input | 1 | Die below the over-temperature recovery point |
| rel_low | input | 1 | Supply below the latch-release level |
| run_en | output | 1 | Switching permitted |
| ss_active | output | 1 | Soft-start window in progress |
| fault_latched | output | 1 | A latching fault is held |

## Verification
The hardest situation to reach is the overload delay being restarted: the compare must stay high for most of the delay in normal run, drop for a couple of cycles and rise again, and the latch must then wait for a full fresh window. The bench reaches it by first walking the machine through soft-start (proving the compare is ignored there), then holding the compare for three quarters of the window, pulsing it low, and observing that the fault stays clear past the original deadline but appears after a complete second window. The feedback over-voltage count is handled the same way, with one clean strobe inserted after seven faulty ones.

// File: rtl/fpg_pkg.sv
package fpg_pkg;
    typedef enum logic [2:0] {
        ST_LOCKOUT   = 3'd0,
        ST_SOFTSTART = 3'd1,
        ST_RUN       = 3'd2,
        ST_THERMAL   = 3'd3,
        ST_LATCHED   = 3'd4
    } fpg_state_e;
endpackage

// File: rtl/fpg_tick.sv
module fpg_tick #(
    parameter int unsigned DIV = 125000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

    assert_tick_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
endmodule

// File: rtl/fpg_ms_timer.sv
module fpg_ms_timer #(
    parameter int unsigned LIMIT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    output logic done
);
    localparam int unsigned W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] TOP = W'(LIMIT);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!en)
            cnt <= '0;
        else if (tick && cnt != TOP)
            cnt <= cnt + 1'b1;
    end

    assign done = en && (cnt == TOP);

    assert_timer_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> cnt == '0);
    assert_timer_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= TOP);
endmodule

// File: rtl/fpg_cycle_debounce.sv
module fpg_cycle_debounce #(
    parameter int unsigned CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic strobe,
    input  logic cond,
    output logic trip
);
    localparam int unsigned W = $clog2(CYCLES + 1);
    localparam logic [W-1:0] TOP = W'(CYCLES);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (strobe) begin
            if (!cond)
                cnt <= '0;
            else if (cnt != TOP)
                cnt <= cnt + 1'b1;
        end
    end

    assign trip = (cnt == TOP);

    assert_clean_cycle_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !cond && !clr) |=> cnt == '0);
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= TOP);
endmodule

// File: rtl/flyback_guard.sv
module flyback_guard
    import fpg_pkg::*;
#(
    parameter int unsigned TICK_DIV     = 125000,
    parameter int unsigned SS_MS        = 5,
    parameter int unsigned OLP_MS       = 40,
    parameter int unsigned FBOVP_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_above_on,
    input  logic sup_below_off,
    input  logic sup_ovp,
    input  logic fb_ovp,
    input  logic fb_uvp,
    input  logic gate_off,
    input  logic cyc_end,
    input  logic ovl_cmp,
    input  logic temp_hot,
    input  logic temp_cool,
    input  logic rel_low,
    output logic run_en,
    output logic ss_active,
    output logic fault_latched
);
    fpg_state_e state, state_nx;

    logic ms_tick;
    logic ss_done;
    logic olp_done;
    logic fbo_trip;
    logic switching;

    assign switching = (state == ST_SOFTSTART) || (state == ST_RUN);

    fpg_tick #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (ms_tick)
    );

    fpg_ms_timer #(.LIMIT(SS_MS)) u_ss_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (state == ST_SOFTSTART),
        .tick (ms_tick),
        .done (ss_done)
    );

    fpg_ms_timer #(.LIMIT(OLP_MS)) u_olp_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .en   ((state == ST_RUN) && ovl_cmp),
        .tick (ms_tick),
        .done (olp_done)
    );

    fpg_cycle_debounce #(.CYCLES(FBOVP_CYCLES)) u_fbo_deb (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!switching),
        .strobe(cyc_end),
        .cond  (fb_ovp),
        .trip  (fbo_trip)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_LOCKOUT;
        else
            state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LOCKOUT: begin
                if (sup_above_on && !temp_hot)
                    state_nx = ST_SOFTSTART;            // power-up
            end
            ST_SOFTSTART, ST_RUN: begin
                if (sup_below_off)
                    state_nx = ST_LOCKOUT;              // brown-out
                else if (sup_ovp)
                    state_nx = ST_LATCHED;              // trip
                else if (fb_uvp && gate_off)
                    state_nx = ST_LATCHED;              // trip
                else if (fbo_trip)
                    state_nx = ST_LATCHED;              // trip
                else if (olp_done)
                    state_nx = ST_LATCHED;              // trip
                else if (temp_hot)
                    state_nx = ST_THERMAL;              // overheat
                else if (state == ST_SOFTSTART && ss_done)
                    state_nx = ST_RUN;                  // ramp-done
            end
            ST_THERMAL: begin
                if (sup_below_off)
                    state_nx = ST_LOCKOUT;              // brown-out
                else if (sup_ovp)
                    state_nx = ST_LATCHED;              // trip
                else if (temp_cool && !temp_hot)
                    state_nx = ST_SOFTSTART;            // cooled
            end
            ST_LATCHED: begin
                if (rel_low)
                    state_nx = ST_LOCKOUT;              // release
            end
            default: state_nx = ST_LOCKOUT;
        endcase
    end

    // Outputs
    always_comb begin
        run_en        = 1'b0;
        ss_active     = 1'b0;
        fault_latched = 1'b0;
        unique case (state)
            ST_SOFTSTART: begin
                run_en    = !sup_ovp;
                ss_active = 1'b1;
            end
            ST_RUN:     run_en        = !sup_ovp;
            ST_LATCHED: fault_latched = 1'b1;
            ST_LOCKOUT, ST_THERMAL: ;
            default: ;
        endcase
    end

    assert_lockout_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCKOUT && !sup_above_on) |=> !run_en);
    assert_brownout_stops_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (switching && sup_below_off) |=> (state == ST_LOCKOUT && !run_en));
    assert_ovp_latches_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_ovp && !sup_below_off && (switching || state == ST_THERMAL)) |=> fault_latched);
    assert_uvp_latches_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (switching && fb_uvp && gate_off && !sup_below_off) |=> fault_latched);
    assert_enable_via_softstart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_en) |-> ss_active);
    assert_latch_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_latched && !rel_low) |=> (fault_latched && !run_en));
    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_latched && rel_low) |=> (!fault_latched && !run_en));
    assert_thermal_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_THERMAL && !temp_cool) |=> !run_en);
endmodule

// File: tb/flyback_guard_tb.sv
module flyback_guard_tb;
    localparam int unsigned TICK_DIV = 4;
    localparam int unsigned SS_MS    = 5;
    localparam int unsigned OLP_MS   = 40;
    localparam int unsigned FBO_N    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sup_above_on, sup_below_off, sup_ovp, fb_ovp, fb_uvp, gate_off;
    logic cyc_end, ovl_cmp, temp_hot, temp_cool, rel_low;
    logic run_en, ss_active, fault_latched;

    int errors = 0;
    int checks = 0;
    bit done_flag = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    flyback_guard #(
        .TICK_DIV(TICK_DIV), .SS_MS(SS_MS), .OLP_MS(OLP_MS), .FBOVP_CYCLES(FBO_N)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .sup_above_on(sup_above_on), .sup_below_off(sup_below_off), .sup_ovp(sup_ovp),
        .fb_ovp(fb_ovp), .fb_uvp(fb_uvp), .gate_off(gate_off), .cyc_end(cyc_end),
        .ovl_cmp(ovl_cmp), .temp_hot(temp_hot), .temp_cool(temp_cool), .rel_low(rel_low),
        .run_en(run_en), .ss_active(ss_active), .fault_latched(fault_latched)
    );

    // Input vector bits: [9]sup_above_on [8]sup_below_off [7]sup_ovp [6]fb_ovp
    // [5]fb_uvp [4]gate_off [3]ovl_cmp [2]temp_hot [1]temp_cool [0]rel_low
    // Expected bits: [2]run_en [1]ss_active [0]fault_latched
    typedef struct packed {
        logic [9:0] ins;
        logic [7:0] hold;
        logic [2:0] exp;
    } vec_t;

    localparam vec_t TBL [8] = '{
        '{10'b0000000010, 8'd3, 3'b000},
        '{10'b0100000010, 8'd3, 3'b000},
        '{10'b0000000010, 8'd3, 3'b000},
        '{10'b1000000010, 8'd1, 3'b110},
        '{10'b0000000010, 8'd2, 3'b110},
        '{10'b0100000010, 8'd1, 3'b000},
        '{10'b0000000010, 8'd3, 3'b000},
        '{10'b1000000010, 8'd2, 3'b110}
    };

    localparam logic [9:0] IDLE = 10'b0000000010;
    localparam logic [9:0] ON   = 10'b1000000010;
    localparam logic [9:0] LOW  = 10'b0100000010;

    task automatic apply(input logic [9:0] v);
        {sup_above_on, sup_below_off, sup_ovp, fb_ovp, fb_uvp, gate_off,
         ovl_cmp, temp_hot, temp_cool, rel_low} = v;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_range(input string tag, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    function automatic int outs();
        return {29'd0, run_en, ss_active, fault_latched};
    endfunction

    // Reach ST_RUN from anywhere non-latched; returns soft-start length in cycles
    task automatic power_up(output int ss_len);
        apply(LOW);
        wait_n(2);
        apply(ON);
        ss_len = 0;
        wait_n(1);
        while (ss_active && ss_len < 400) begin
            ss_len++;
            wait_n(1);
        end
        ss_len++;
        apply(IDLE);
    endtask

    task automatic strobe(input logic ovp);
        fb_ovp = ovp;
        cyc_end = 1'b1;
        wait_n(1);
        cyc_end = 1'b0;
        wait_n(2);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int ss_len;
        apply(IDLE);
        cyc_end = 1'b0;
        wait_n(3);
        chk("R10 outputs in reset", outs(), 0);
        rst_n = 1'b1;
        wait_n(2);
        chk("R10 outputs after reset", outs(), 0);

        // R1 hysteresis table
        foreach (TBL[i]) begin
            apply(TBL[i].ins);
            wait_n(int'(TBL[i].hold));
            chk($sformatf("R1 table step %0d", i), outs(), int'(TBL[i].exp));
        end

        // R5 soft-start length
        power_up(ss_len);
        chk_range("R5 soft-start cycles", ss_len, (SS_MS-1)*TICK_DIV+1, SS_MS*TICK_DIV+2);
        chk("R5 run after soft-start", outs(), 3'b100);

        // R6 overload ignored during soft-start, then restart of the delay
        apply(LOW); wait_n(2);
        apply(ON | 10'b0000001000);
        wait_n(SS_MS*TICK_DIV + 4);
        chk("R6 soft-start ignores overload", outs(), 3'b100);
        apply(IDLE | 10'b0000001000);
        wait_n(30*TICK_DIV);
        chk("R6 no latch before delay", outs(), 3'b100);
        apply(IDLE); wait_n(2);
        apply(IDLE | 10'b0000001000);
        wait_n(30*TICK_DIV);
        chk("R6 delay restarted after drop", outs(), 3'b100);
        wait_n(15*TICK_DIV);
        chk("R6 overload latched", outs(), 3'b001);

        // R7 latched ignores supply flags
        apply(ON); wait_n(4);
        chk("R7 turn-on ignored while latched", outs(), 3'b001);
        apply(LOW); wait_n(3);
        chk("R7 turn-off ignored while latched", outs(), 3'b001);

        // R8 release then fresh turn-on needed
        apply(LOW | 10'b0000000001); wait_n(1);
        chk("R8 release clears latch", outs(), 3'b000);
        apply(IDLE); wait_n(4);
        chk("R8 lockout after release", outs(), 3'b000);
        apply(ON); wait_n(1);
        chk("R8 restart with turn-on", outs(), 3'b110);

        // R2 supply over-voltage immediate cut and latch
        power_up(ss_len);
        apply(IDLE | 10'b0010000000); #1;
        chk("R2 run_en cut same cycle", int'(run_en), 0);
        wait_n(1);
        chk("R2 latched next cycle", outs(), 3'b001);
        apply(LOW | 10'b0000000001); wait_n(1); apply(IDLE); wait_n(1);

        // R3 feedback over-voltage debounce
        power_up(ss_len);
        for (int k = 0; k < FBO_N-1; k++) strobe(1'b1);
        chk("R3 no latch after N-1 strobes", outs(), 3'b100);
        strobe(1'b0);
        for (int k = 0; k < FBO_N-1; k++) strobe(1'b1);
        chk("R3 count restarted by clean cycle", outs(), 3'b100);
        strobe(1'b1);
        chk("R3 latched after N strobes", outs(), 3'b001);
        fb_ovp = 1'b0;
        apply(LOW | 10'b0000000001); wait_n(1); apply(IDLE); wait_n(1);

        // R4 feedback under-voltage only in gate-off
        power_up(ss_len);
        apply(IDLE | 10'b0000100000); wait_n(5);
        chk("R4 ignored during gate-on", outs(), 3'b100);
        apply(IDLE | 10'b0000110000); wait_n(1);
        chk("R4 latched in gate-off", outs(), 3'b001);
        apply(LOW | 10'b0000000001); wait_n(1); apply(IDLE); wait_n(1);

        // R9 over-temperature
        power_up(ss_len);
        apply(10'b0000000100); wait_n(1);
        chk("R9 hot stops switching without latch", outs(), 3'b000);
        apply(10'b0000000000); wait_n(4);
        chk("R9 stays off until cool", outs(), 3'b000);
        apply(IDLE); wait_n(1);
        chk("R9 resumes via soft-start", outs(), 3'b110);
        apply(LOW); wait_n(2);
        apply(ON | 10'b0000000100); wait_n(4);
        chk("R9 hot blocks power-up", outs(), 3'b000);
        apply(IDLE); wait_n(2);

        finish_run();
    end
endmodule